// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a 32-bit operand by an amount read from a general register and works out the carry flag that the operation produces. The caller supplies the operand, the full amount register, a two-bit operation selector and the current carry flag. Only the low byte of the amount register counts, so amounts run from 0 to 255. The rules for the carry flag differ between the four operations at amounts of zero, exactly the word width, and beyond it.

The datapath is a logarithmic barrel network. It does right shifts and right rotates directly. A left shift is done by reversing the bit order before and after the network. The carry is picked by a separate selector that works beside the barrel. The value and the carry are captured together in one pipeline register. Both appear one clock after the inputs are presented.

Top module: `shf_regshift`

## Requirements
- R1: Only bits 7:0 of `amount_i` set the amount. Any value in bits 31:8 gives the same result and carry as the same low byte with zeros above it.
- R2: When the amount is zero, the result equals the operand and the carry out equals `carry_i`. This holds for every operation code.
- R3: Operation code 00 is logical left. For an amount n from 1 to 31, the result is the operand shifted left by n with zeros entering, and the carry is operand bit 32-n.
- R4: For logical left (00), an amount of exactly 32 gives result 0 and carry equal to operand bit 0. Any amount above 32 gives result 0 and carry 0.
- R5: Operation code 01 is logical right. For n from 1 to 32, the result is the operand shifted right with zeros entering, and the carry is operand bit n-1. Any amount above 32 gives result 0 and carry 0.
- R6: Operation code 10 is arithmetic right. For n from 1 to 31, copies of bit 31 enter from the top and the carry is operand bit n-1. For n of 32 or more, every result bit equals operand bit 31 and so does the carry.
- R7: Operation code 11 is rotate right by the amount modulo 32. When the amount is a nonzero multiple of 32, the result is the operand and the carry is bit 31. Otherwise the carry is operand bit (amount mod 32)-1, which is also the new bit 31.
- R8: While `rst_n` is low, the result and the carry read 0. The result and carry for a set of inputs appear on the outputs exactly one rising clock edge after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| operand_i | input | 32 | Value to shift or rotate |
| amount_i | input | 32 | Amount register; only bits 7:0 are used |
| kind_i | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag, passed through when the amount is zero |
| result_o | output | 32 | Shifted or rotated value, registered |
| carry_o | output | 1 | New carry flag, registered |

## Verification
The checker assumes that every input has a known value at each rising edge once reset is released. It also compares registered outputs with the inputs of the previous edge, which is only meaningful if the bench changes the inputs only between edges. The bench drives every input from the falling edge and holds it stable through the next rising edge. It never leaves an input undriven, even while reset is held. The out-of-range properties only look at the low byte of the amount, so the bench also puts nonzero bits above bit 7 to confirm that the checker and the design ignore them alike.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shk_e;

endpackage

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  op_i,
    input  logic [SW-1:0] shamt_i,
    input  shk_e          kind_i,
    input  logic          flood_i,
    output logic [W-1:0]  res_o
);

    logic          is_left;
    logic          is_rot;
    logic          fill;
    logic [W-1:0]  pre;
    logic [W-1:0]  post;
    logic [W-1:0]  stg [SW+1];

    assign is_left = (kind_i == SHK_LSL);
    assign is_rot  = (kind_i == SHK_ROR);
    assign fill    = (kind_i == SHK_ASR) ? op_i[W-1] : 1'b0;

    // bit reversal so that a left shift reuses the right-shift network
    generate
        for (genvar b = 0; b < W; b++) begin : g_rev
            assign pre[b]   = is_left ? op_i[W-1-b] : op_i[b];
            assign res_o[b] = is_left ? post[W-1-b] : post[b];
        end
    endgenerate

    assign stg[0] = pre;

    generate
        for (genvar s = 0; s < SW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            logic [W-1:0] rot_v;
            logic [W-1:0] shr_v;
            assign rot_v = {stg[s][STEP-1:0], stg[s][W-1:STEP]};
            assign shr_v = {{STEP{fill}}, stg[s][W-1:STEP]};
            assign stg[s+1] = !shamt_i[s] ? stg[s] : (is_rot ? rot_v : shr_v);
        end
    endgenerate

    assign post = flood_i ? {W{fill}} : stg[SW];

endmodule

// File: rtl/shf_carry_sel.sv
module shf_carry_sel
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  op_i,
    input  logic [AW-1:0] amt_i,
    input  shk_e          kind_i,
    input  logic          carry_i,
    output logic          carry_o
);

    localparam logic [AW-1:0] WV  = AW'(W);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] idx;
    logic [SW-1:0] rmod;

    always_comb begin
        idx     = '0;
        rmod    = amt_i[SW-1:0];
        carry_o = 1'b0;
        if (amt_i == '0) begin
            carry_o = carry_i;
        end else begin
            unique case (kind_i)
                SHK_LSL: begin
                    idx = WV - amt_i;
                    if (amt_i < WV)       carry_o = op_i[idx[SW-1:0]];
                    else if (amt_i == WV) carry_o = op_i[0];
                    else                  carry_o = 1'b0;
                end
                SHK_LSR: begin
                    idx = amt_i - ONE;
                    if (amt_i < WV)       carry_o = op_i[idx[SW-1:0]];
                    else if (amt_i == WV) carry_o = op_i[W-1];
                    else                  carry_o = 1'b0;
                end
                SHK_ASR: begin
                    idx = amt_i - ONE;
                    if (amt_i < WV) carry_o = op_i[idx[SW-1:0]];
                    else            carry_o = op_i[W-1];
                end
                default: begin
                    if (rmod == '0) begin
                        carry_o = op_i[W-1];
                    end else begin
                        idx     = AW'(rmod) - ONE;
                        carry_o = op_i[idx[SW-1:0]];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/shf_regshift.sv
module shf_regshift
    import shf_pkg::*;
#(
    parameter int W     = 32,
    parameter int REG_W = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     operand_i,
    input  logic [REG_W-1:0] amount_i,
    input  logic [1:0]       kind_i,
    input  logic             carry_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o
);

    localparam int SW = $clog2(W);
    localparam logic [AW-1:0] WV = AW'(W);

    typedef struct packed {
        logic [W-1:0] value;
        logic         carry;
    } shf_out_t;

    logic [AW-1:0]       amt;
    logic [REG_W-AW-1:0] amt_hi_unused;
    shk_e                kind;
    logic                flood;
    logic [W-1:0]        barrel_res;
    logic                carry_sel;
    shf_out_t            st_d;
    shf_out_t            st_q;

    assign amt           = amount_i[AW-1:0];
    assign amt_hi_unused = amount_i[REG_W-1:AW];
    assign kind          = shk_e'(kind_i);
    assign flood         = (kind != SHK_ROR) && (amt >= WV);

    shf_barrel #(.W(W), .SW(SW)) u_barrel (
        .op_i    (operand_i),
        .shamt_i (amt[SW-1:0]),
        .kind_i  (kind),
        .flood_i (flood),
        .res_o   (barrel_res)
    );

    shf_carry_sel #(.W(W), .AW(AW), .SW(SW)) u_carry (
        .op_i    (operand_i),
        .amt_i   (amt),
        .kind_i  (kind),
        .carry_i (carry_i),
        .carry_o (carry_sel)
    );

    always_comb begin
        st_d.value = (amt == '0) ? operand_i : barrel_res;
        st_d.carry = carry_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.value;
    assign carry_o  = st_q.carry;

endmodule

// File: rtl/shf_regshift_chk.sv
module shf_regshift_chk #(
    parameter int W     = 32,
    parameter int REG_W = 32,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     operand_i,
    input logic [REG_W-1:0] amount_i,
    input logic [1:0]       kind_i,
    input logic             carry_i,
    input logic [W-1:0]     result_o,
    input logic             carry_o
);

    localparam logic [AW-1:0] WV = AW'(W);

    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(amount_i[AW-1:0]) == '0)
        |-> (result_o == $past(operand_i) && carry_o == $past(carry_i))); // R2

    AST_LSL_FAR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(kind_i) == 2'b00 && $past(amount_i[AW-1:0]) > WV)
        |-> (result_o == '0 && !carry_o)); // R4

    AST_LSR_FAR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(kind_i) == 2'b01 && $past(amount_i[AW-1:0]) > WV)
        |-> (result_o == '0 && !carry_o)); // R5

    AST_ASR_FLOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(kind_i) == 2'b10 && $past(amount_i[AW-1:0]) >= WV)
        |-> (result_o == {W{$past(operand_i[W-1])}} && carry_o == $past(operand_i[W-1]))); // R6

    AST_ROR_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(kind_i) == 2'b11)
        |-> ($countones(result_o) == $countones($past(operand_i)))); // R7

endmodule

bind shf_regshift shf_regshift_chk #(.W(W), .REG_W(REG_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .kind_i    (kind_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
);

// File: tb/sim_shf_regshift.sv
`timescale 1ns/1ps
module sim_shf_regshift;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] amount_i = '0;
    logic [1:0]  kind_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    shf_regshift u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (operand_i),
        .amount_i  (amount_i),
        .kind_i    (kind_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] op;
        logic [31:0] amt;
        logic [1:0]  kind;
        logic        cin;
        logic [31:0] ev;
        logic        ec;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{4'd2, 32'h8000_0001, 32'd0,         2'b00, 1'b1, 32'h8000_0001, 1'b1}, // R2
        '{4'd3, 32'h8000_0001, 32'd1,         2'b00, 1'b0, 32'h0000_0002, 1'b1}, // R3
        '{4'd3, 32'h0000_000F, 32'd4,         2'b00, 1'b1, 32'h0000_00F0, 1'b0}, // R3
        '{4'd4, 32'h0000_0001, 32'd32,        2'b00, 1'b0, 32'h0000_0000, 1'b1}, // R4
        '{4'd4, 32'hFFFF_FFFF, 32'd33,        2'b00, 1'b1, 32'h0000_0000, 1'b0}, // R4
        '{4'd5, 32'h0000_00F0, 32'd5,         2'b01, 1'b0, 32'h0000_0007, 1'b1}, // R5
        '{4'd5, 32'h8000_0000, 32'd32,        2'b01, 1'b0, 32'h0000_0000, 1'b1}, // R5
        '{4'd5, 32'h8000_0000, 32'd200,       2'b01, 1'b1, 32'h0000_0000, 1'b0}, // R5
        '{4'd6, 32'h8000_0000, 32'd4,         2'b10, 1'b1, 32'hF800_0000, 1'b0}, // R6
        '{4'd6, 32'h8000_0010, 32'd40,        2'b10, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R6
        '{4'd6, 32'h7FFF_FFFF, 32'd32,        2'b10, 1'b1, 32'h0000_0000, 1'b0}, // R6
        '{4'd7, 32'h0000_0001, 32'd1,         2'b11, 1'b0, 32'h8000_0000, 1'b1}, // R7
        '{4'd7, 32'h1234_5678, 32'd8,         2'b11, 1'b1, 32'h7812_3456, 1'b0}, // R7
        '{4'd7, 32'h8000_0000, 32'd64,        2'b11, 1'b0, 32'h8000_0000, 1'b1}, // R7
        '{4'd7, 32'h0000_0003, 32'd33,        2'b11, 1'b0, 32'h8000_0001, 1'b1}, // R7
        '{4'd1, 32'h0000_0055, 32'h0000_0100, 2'b01, 1'b0, 32'h0000_0055, 1'b0}, // R1
        '{4'd1, 32'h0000_0001, 32'hFFFF_FF01, 2'b00, 1'b1, 32'h0000_0002, 1'b0}, // R1
        '{4'd2, 32'hABCD_0000, 32'd0,         2'b11, 1'b0, 32'hABCD_0000, 1'b0}  // R2
    };

    task automatic chk(input int req, input logic [31:0] ev, input logic ec);
        n_chk++;
        if (result_o !== ev || carry_o !== ec) begin
            n_err++;
            $display("FAIL R%0d: result=%h carry=%b expected result=%h carry=%b",
                     req, result_o, carry_o, ev, ec);
        end
    endtask

    task automatic drive(input logic [31:0] op, input logic [31:0] amt,
                         input logic [1:0] k, input logic cin);
        @(negedge clk);
        operand_i = op;
        amount_i  = amt;
        kind_i    = k;
        carry_i   = cin;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #40000;
        n_chk++;
        n_err++;
        $display("FAIL R8: watchdog expired, done=0 expected 1");
        finish_run();
    end

    initial begin
        // R8: reset clears outputs even with active inputs
        drive(32'hFFFF_FFFF, 32'd3, 2'b10, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk(8, 32'h0, 1'b0);

        @(negedge clk);
        rst_n = 1'b1;

        // table walk, one result per vector one edge later
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].op, TBL[i].amt, TBL[i].kind, TBL[i].cin);
            @(posedge clk);
            #1;
            chk(int'(TBL[i].req), TBL[i].ev, TBL[i].ec);
        end

        // R8: latency, output holds until the next edge
        drive(32'h0000_00F0, 32'd4, 2'b01, 1'b0);
        @(posedge clk);
        #1;
        chk(8, 32'h0000_000F, 1'b0);
        drive(32'hDEAD_BEEF, 32'd0, 2'b00, 1'b1);
        #0.5;
        chk(8, 32'h0000_000F, 1'b0);
        @(posedge clk);
        #1;
        chk(8, 32'hDEAD_BEEF, 1'b1);

        // R3: largest in-range left shift, carry from bit 1
        drive(32'h0000_0003, 32'd31, 2'b00, 1'b0);
        @(posedge clk);
        #1;
        chk(3, 32'h8000_0000, 1'b1);

        // R5: logical right by 31 keeps top bit only, carry from bit 30
        drive(32'hC000_0000, 32'd31, 2'b01, 1'b0);
        @(posedge clk);
        #1;
        chk(5, 32'h0000_0001, 1'b1);

        // R6: arithmetic right by 255 of a positive value
        drive(32'h4000_0000, 32'hFFFF_FFFF, 2'b10, 1'b1);
        @(posedge clk);
        #1;
        chk(6, 32'h0000_0000, 1'b0);

        // R8: reset mid-run clears the outputs again
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(8, 32'h0, 1'b0);

        finish_run();
    end

endmodule